// File: doc/BRIEF.md
# Time-of-year seconds counter

This block keeps a 32-bit count of seconds in a slow, always-on clock domain that a 32.768 kHz crystal drives. A programmable trim divider sits in front of the counter. The counter advances once every trim+1 slow-clock cycles, so a trim of 32767 gives one increment per second. Because the slow domain has its own clock and its own reset, counting can go on while the rest of the chip sleeps.

Software reaches the block through four registers in a fast bus clock domain. Writes to the trim register and to the counter-load register are carried across to the slow domain by a toggle handshake. Each of these two registers has its own pending flag, which stays set until the slow domain has taken the new value. The counter value comes back to the bus domain through a second handshake. The read register therefore always holds one coherent snapshot. A bus-side edge counter watches the slow clock and reports whether the oscillator is running.

Top module: `toy_seconds_counter`

## Requirements
- R1: After reset the control/status register (address 0) reads 0. The trim register (address 1) reads TRIM_RST, which defaults to 32767. The load register (address 2) and the count register (address 3) read 0.
- R2: While the counter is enabled, it increments once every trim+1 slow-clock cycles, where trim is the committed value of address 1.
- R3: A write to address 2 loads that value into the counter and clears the prescaler. The first increment after a load comes trim+1 slow cycles later.
- R4: Status bit 3 (load pending) is set by an accepted write to address 2 and clears once the slow domain has committed the value.
- R5: Status bit 2 (trim pending) is set by an accepted write to address 1 and clears once the slow domain has committed it. Address 1 reads back the last accepted trim value.
- R6: A write to address 1 or 2 that arrives while that register's pending bit is set is ignored. The earlier write completes unchanged.
- R7: Status bit 0 (enable) is written through address 0, bit 0, and reads back. While it is 0 the counter holds its value.
- R8: Status bit 1 (oscillator detected) sets after OSC_EDGES rising slow-clock edges have been seen in the bus domain. It clears after OSC_TIMEOUT bus cycles pass with no slow edge.
- R9: Address 3 returns a counter value captured whole in the slow domain and handed across by handshake. The captured value is held stable until the bus side has taken it.
- R10: The counter wraps from 0xFFFFFFFF to 0 and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control/status, 1 trim, 2 load, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr, one cycle after the address |
| slow_clk | input | 1 | 32.768 kHz counting clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |

## Verification
The assertions assume that the slow clock is several bus cycles slower per half period than the bus clock, so that each two-flop synchronizer catches every toggle. They also assume that both resets are applied together, so the handshake toggles start out matched. The bench runs the slow clock ten times slower than the bus clock and holds both resets across several slow edges. It samples the count register in the middle of a tick period, well clear of the few slow cycles of read-handshake latency. The slow clock is stopped only while the clock is low, and only to exercise the oscillator timeout.

// File: rtl/toy_pkg.sv
package toy_pkg;
  localparam int unsigned CNT_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TRIM = 2'd1,
    REG_LOAD = 2'd2,
    REG_READ = 2'd3
  } toy_reg_e;

  localparam int unsigned ST_EN        = 0;
  localparam int unsigned ST_OSC       = 1;
  localparam int unsigned ST_TRIM_PEND = 2;
  localparam int unsigned ST_LOAD_PEND = 3;
endpackage

// File: rtl/toy_wr_xfer.sv
module toy_wr_xfer #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         b_clk,
  input  logic         b_rst,
  input  logic         b_wr,
  input  logic [W-1:0] b_data,
  output logic         b_pend,
  output logic [W-1:0] b_hold,
  input  logic         s_clk,
  input  logic         s_rst,
  output logic         s_load
);
  logic         req_q, ack_m, ack_s;
  logic [W-1:0] hold_q;
  logic         req_m, req_s, s_ack_q;

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      req_q  <= 1'b0;
      ack_m  <= 1'b0;
      ack_s  <= 1'b0;
      hold_q <= RST_VAL;
    end else begin
      ack_m <= s_ack_q;
      ack_s <= ack_m;
      if (b_wr && !b_pend) begin
        hold_q <= b_data;
        req_q  <= ~req_q;
      end
    end
  end

  assign b_pend = req_q != ack_s;
  assign b_hold = hold_q;

  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      req_m   <= 1'b0;
      req_s   <= 1'b0;
      s_ack_q <= 1'b0;
    end else begin
      req_m   <= req_q;
      req_s   <= req_m;
      s_ack_q <= req_s;
    end
  end

  assign s_load = req_s != s_ack_q;

  // R6
  wr_ignore_chk: assert property (@(posedge b_clk) disable iff (b_rst)
    (b_wr && b_pend) |=> $stable(hold_q));

  // R4
  load_pulse_chk: assert property (@(posedge s_clk) disable iff (s_rst)
    s_load |=> !s_load);
endmodule

// File: rtl/toy_rd_xfer.sv
module toy_rd_xfer #(
  parameter int unsigned W = 32
) (
  input  logic         s_clk,
  input  logic         s_rst,
  input  logic [W-1:0] s_val,
  input  logic         b_clk,
  input  logic         b_rst,
  output logic [W-1:0] b_val
);
  logic         s_tgl, ack_m, ack_s;
  logic [W-1:0] snap_q;
  logic         tgl_m, tgl_s, b_ack;
  logic [W-1:0] val_q;

  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      s_tgl  <= 1'b0;
      ack_m  <= 1'b0;
      ack_s  <= 1'b0;
      snap_q <= '0;
    end else begin
      ack_m <= b_ack;
      ack_s <= ack_m;
      if (s_tgl == ack_s) begin
        snap_q <= s_val;
        s_tgl  <= ~s_tgl;
      end
    end
  end

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      tgl_m <= 1'b0;
      tgl_s <= 1'b0;
      b_ack <= 1'b0;
      val_q <= '0;
    end else begin
      tgl_m <= s_tgl;
      tgl_s <= tgl_m;
      if (tgl_s != b_ack) begin
        val_q <= snap_q;
        b_ack <= tgl_s;
      end
    end
  end

  assign b_val = val_q;

  // R9
  snap_hold_chk: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_tgl != ack_s) |=> $stable(snap_q));

  // R9
  rd_take_chk: assert property (@(posedge b_clk) disable iff (b_rst)
    (tgl_s != b_ack) |=> (val_q == $past(snap_q)));
endmodule

// File: rtl/toy_osc_detect.sv
module toy_osc_detect #(
  parameter int unsigned EDGES   = 8,
  parameter int unsigned TIMEOUT = 16384
) (
  input  logic b_clk,
  input  logic b_rst,
  input  logic s_clk,
  input  logic s_rst,
  output logic b_ok
);
  localparam int unsigned EW = $clog2(EDGES + 1);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  logic          s_div;
  logic          d_m, d_s, d_p;
  logic          edge_seen;
  logic [EW-1:0] edge_cnt;
  logic [TW-1:0] tmo_q;
  logic          ok_q;

  always_ff @(posedge s_clk) begin
    if (s_rst) s_div <= 1'b0;
    else       s_div <= ~s_div;
  end

  assign edge_seen = d_s ^ d_p;

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      d_m      <= 1'b0;
      d_s      <= 1'b0;
      d_p      <= 1'b0;
      edge_cnt <= '0;
      tmo_q    <= '0;
      ok_q     <= 1'b0;
    end else begin
      d_m <= s_div;
      d_s <= d_m;
      d_p <= d_s;
      if (edge_seen) begin
        tmo_q <= '0;
        if (edge_cnt != EW'(EDGES)) edge_cnt <= edge_cnt + 1'b1;
      end else if (tmo_q == TW'(TIMEOUT)) begin
        edge_cnt <= '0;
      end else begin
        tmo_q <= tmo_q + 1'b1;
      end
      ok_q <= (edge_cnt == EW'(EDGES));
    end
  end

  assign b_ok = ok_q;

  // R8
  osc_drop_chk: assert property (@(posedge b_clk) disable iff (b_rst)
    $fell(ok_q) |-> $past(tmo_q == TW'(TIMEOUT)));

  // R8
  osc_bound_chk: assert property (@(posedge b_clk) disable iff (b_rst)
    edge_cnt <= EW'(EDGES));
endmodule

// File: rtl/toy_slow_core.sv
module toy_slow_core #(
  parameter int unsigned TRIM_W   = 16,
  parameter int unsigned CW       = 32,
  parameter logic [TRIM_W-1:0] TRIM_RST = 16'd32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              trim_ld,
  input  logic [TRIM_W-1:0] trim_d,
  input  logic              cnt_ld,
  input  logic [CW-1:0]     cnt_d,
  output logic [CW-1:0]     cnt
);
  logic [TRIM_W-1:0] trim_q, presc_q;
  logic [CW-1:0]     cnt_q;
  logic              tick;

  assign tick = en && (presc_q >= trim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_q  <= TRIM_RST;
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (trim_ld) trim_q <= trim_d;
      if (cnt_ld) begin
        cnt_q   <= cnt_d;
        presc_q <= '0;
      end else if (tick) begin
        cnt_q   <= cnt_q + 1'b1;
        presc_q <= '0;
      end else if (en) begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign cnt = cnt_q;

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_ld |=> (cnt_q == $past(cnt_d)) && (presc_q == '0));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && tick && (cnt_q == '1)) |=> (cnt_q == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ld && !tick) |=> $stable(cnt_q));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_ld) |=> ($stable(cnt_q) && $stable(presc_q)));
endmodule

// File: rtl/toy_seconds_counter.sv
module toy_seconds_counter #(
  parameter int unsigned TRIM_W      = 16,
  parameter int unsigned TRIM_RST    = 32767,
  parameter int unsigned OSC_EDGES   = 8,
  parameter int unsigned OSC_TIMEOUT = 16384
) (
  input  logic        bus_clk,
  input  logic        bus_rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        slow_clk,
  input  logic        slow_rst
);
  import toy_pkg::*;

  localparam logic [TRIM_W-1:0] TRIM_INIT = TRIM_W'(TRIM_RST);

  logic              en_q, en_m, en_s;
  logic              trim_pend, load_pend, osc_ok;
  logic [TRIM_W-1:0] trim_hold;
  logic [CNT_W-1:0]  load_hold, rd_val, cnt_s;
  logic              s_trim_ld, s_cnt_ld;
  logic [31:0]       status, rdata_q;

  toy_wr_xfer #(.W(TRIM_W), .RST_VAL(TRIM_INIT)) u_trim_x (
    .b_clk(bus_clk), .b_rst(bus_rst),
    .b_wr(bus_wr && (bus_addr == REG_TRIM)),
    .b_data(bus_wdata[TRIM_W-1:0]),
    .b_pend(trim_pend), .b_hold(trim_hold),
    .s_clk(slow_clk), .s_rst(slow_rst), .s_load(s_trim_ld)
  );

  toy_wr_xfer #(.W(CNT_W), .RST_VAL('0)) u_load_x (
    .b_clk(bus_clk), .b_rst(bus_rst),
    .b_wr(bus_wr && (bus_addr == REG_LOAD)),
    .b_data(bus_wdata),
    .b_pend(load_pend), .b_hold(load_hold),
    .s_clk(slow_clk), .s_rst(slow_rst), .s_load(s_cnt_ld)
  );

  toy_rd_xfer #(.W(CNT_W)) u_rd_x (
    .s_clk(slow_clk), .s_rst(slow_rst), .s_val(cnt_s),
    .b_clk(bus_clk), .b_rst(bus_rst), .b_val(rd_val)
  );

  toy_osc_detect #(.EDGES(OSC_EDGES), .TIMEOUT(OSC_TIMEOUT)) u_osc (
    .b_clk(bus_clk), .b_rst(bus_rst),
    .s_clk(slow_clk), .s_rst(slow_rst), .b_ok(osc_ok)
  );

  toy_slow_core #(.TRIM_W(TRIM_W), .CW(CNT_W), .TRIM_RST(TRIM_INIT)) u_core (
    .clk(slow_clk), .rst(slow_rst), .en(en_s),
    .trim_ld(s_trim_ld), .trim_d(trim_hold),
    .cnt_ld(s_cnt_ld), .cnt_d(load_hold),
    .cnt(cnt_s)
  );

  always_ff @(posedge bus_clk) begin
    if (bus_rst) en_q <= 1'b0;
    else if (bus_wr && (bus_addr == REG_CTRL)) en_q <= bus_wdata[ST_EN];
  end

  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      en_m <= 1'b0;
      en_s <= 1'b0;
    end else begin
      en_m <= en_q;
      en_s <= en_m;
    end
  end

  always_comb begin
    status               = '0;
    status[ST_EN]        = en_q;
    status[ST_OSC]       = osc_ok;
    status[ST_TRIM_PEND] = trim_pend;
    status[ST_LOAD_PEND] = load_pend;
  end

  always_ff @(posedge bus_clk) begin
    if (bus_rst) rdata_q <= '0;
    else begin
      case (toy_reg_e'(bus_addr))
        REG_CTRL: rdata_q <= status;
        REG_TRIM: rdata_q <= 32'(trim_hold);
        REG_LOAD: rdata_q <= load_hold;
        default:  rdata_q <= rd_val;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  // R4
  load_pend_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_wr && (bus_addr == REG_LOAD)) |=> load_pend);

  // R5
  trim_pend_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_wr && (bus_addr == REG_TRIM)) |=> trim_pend);
endmodule

// File: tb/tb_toy_seconds_counter.sv
`timescale 1ns/1ps
module tb_toy_seconds_counter;
  logic        bus_clk = 1'b0;
  logic        bus_rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slow_clk = 1'b0;
  logic        slow_rst = 1'b1;
  logic        slow_run = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  toy_seconds_counter #(.OSC_TIMEOUT(64)) dut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_clk(slow_clk), .slow_rst(slow_rst)
  );

  always #2 bus_clk = ~bus_clk;

  initial begin
    forever begin
      #20;
      if (slow_run) slow_clk = ~slow_clk;
    end
  end

  localparam int NV = 5;
  localparam logic [31:0] VT [NV] = '{32'd11, 32'd15, 32'd11, 32'd31, 32'd11};
  localparam logic [31:0] VL [NV] = '{32'd100, 32'h1234_5678, 32'd0, 32'd500, 32'hFFFF_FFFE};
  localparam logic [31:0] VK [NV] = '{32'd3, 32'd2, 32'd5, 32'd1, 32'd3};
  localparam logic [31:0] VE [NV] = '{32'd103, 32'h1234_567A, 32'd5, 32'd501, 32'd1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a;
    @(negedge bus_clk);
    @(negedge bus_clk);
    d = bus_rdata;
  endtask

  task automatic wait_clear(input int bitpos);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd0, s);
      if (!s[bitpos]) return;
    end
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v1;
    wait_slow(6);
    @(negedge bus_clk);
    bus_rst = 1'b0; slow_rst = 1'b0;

    // R1 reset values
    rd(2'd0, d); chk("R1 status", d, 32'd0);
    rd(2'd1, d); chk("R1 trim", d, 32'd32767);
    rd(2'd2, d); chk("R1 load", d, 32'd0);
    rd(2'd3, d); chk("R1 count", d, 32'd0);

    // R8 oscillator detected after edges
    wait_slow(20);
    rd(2'd0, d); chk("R8 osc set", {31'd0, d[1]}, 32'd1);

    // R7 enable readback
    wr(2'd0, 32'd1);
    rd(2'd0, d); chk("R7 enable bit", {31'd0, d[0]}, 32'd1);

    // R2 R3 R10 table walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VT[i]);
      if (i == 0) begin
        rd(2'd0, d); chk("R5 trim pending set", {31'd0, d[2]}, 32'd1);
      end
      wait_clear(2);
      if (i == 0) begin
        rd(2'd0, d); chk("R5 trim pending clear", {31'd0, d[2]}, 32'd0);
        rd(2'd1, d); chk("R5 trim readback", d, VT[i]);
      end
      wr(2'd2, VL[i]);
      if (i == 0) begin
        rd(2'd0, d); chk("R4 load pending set", {31'd0, d[3]}, 32'd1);
      end
      wait_clear(3);
      if (i == 0) begin
        rd(2'd0, d); chk("R4 load pending clear", {31'd0, d[3]}, 32'd0);
      end
      wait_slow(int'((VT[i] + 1) / 2 + (VT[i] + 1) * VK[i]));
      rd(2'd3, d);
      chk(i == 4 ? "R10 wrap count" : "R2 R3 count after ticks", d, VE[i]);
    end

    // R3 first tick one full period after load
    wr(2'd2, 32'd40);
    wait_clear(3);
    wait_slow(10);
    rd(2'd3, d); chk("R3 no early tick", d, 32'd40);

    // R6 ignored second load while pending
    wr(2'd2, 32'd1000);
    wr(2'd2, 32'd2000);
    wait_clear(3);
    wait_slow(6);
    rd(2'd3, d); chk("R6 load kept", d, 32'd1000);
    rd(2'd2, d); chk("R6 load readback", d, 32'd1000);

    // R6 ignored second trim while pending
    wr(2'd1, 32'd23);
    wr(2'd1, 32'd5);
    wait_clear(2);
    rd(2'd1, d); chk("R6 trim kept", d, 32'd23);
    wr(2'd2, 32'd10);
    wait_clear(3);
    wait_slow(12 + 24);
    rd(2'd3, d); chk("R6 trim rate", d, 32'd11);

    // R7 disabled counter holds
    wr(2'd0, 32'd0);
    rd(2'd0, d); chk("R7 enable cleared", {31'd0, d[0]}, 32'd0);
    wait_slow(6);
    rd(2'd3, v1);
    wait_slow(72);
    rd(2'd3, d); chk("R7 frozen count", d, v1);

    // R8 timeout clears detection, restart sets it
    @(negedge slow_clk);
    slow_run = 1'b0;
    repeat (120) @(posedge bus_clk);
    rd(2'd0, d); chk("R8 osc lost", {31'd0, d[1]}, 32'd0);
    slow_run = 1'b1;
    wait_slow(20);
    rd(2'd0, d); chk("R8 osc back", {31'd0, d[1]}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule